// File: doc/BRIEF.md
# Postfix Stack Expression Evaluator

This block evaluates arithmetic expressions written in postfix order. It holds a small operand stack and takes one instruction at a time over a valid/ready handshake. A load instruction carries a memory address. It reads the word stored there and pushes it onto the stack. A store instruction also carries an address. It pops the top entry and writes it to memory at that address. The add and subtract instructions carry no operand of their own. They combine the two uppermost stack entries and leave the result in place of those two entries.

An assignment such as `X = Y + Z` is fed to the block as load Y, load Z, add, store X. Only one memory access is in progress at a time. The memory port reads asynchronously: the word at `mem_addr` must be present on `mem_rdata` in the same cycle that `mem_rd` is high. A write takes effect on the rising edge that ends the cycle in which `mem_wr` is high. Two sticky status flags report a push onto a full stack and a pop from a stack that holds too few entries.

Top module: `zs_eval`

## Requirements
- R1: After reset, `instr_ready` is high, `ovf_flag` and `unf_flag` are low, `mem_rd` and `mem_wr` are low, and the stack is empty.
- R2: An instruction is accepted on a rising edge at which `instr_valid` and `instr_ready` are both high. A load or store that goes on to access memory holds `instr_ready` low for exactly the one cycle after acceptance. In that cycle exactly one of `mem_rd` and `mem_wr` is high. Both strobes drop in the following cycle.
- R3: A load (`instr_op` = 0) that finds the stack not full drives `mem_rd` high and `mem_addr` equal to its address in the cycle after acceptance. The word on `mem_rdata` in that cycle is pushed onto the stack.
- R4: A store (`instr_op` = 1) that finds the stack not empty drives `mem_wr` high in the cycle after acceptance. In that cycle `mem_addr` equals its address and `mem_wdata` equals the top entry. The top entry is then popped.
- R5: Add (`instr_op` = 2) replaces the two top entries with their sum, taken modulo 2^16.
- R6: Subtract (`instr_op` = 3) replaces the two top entries with the second-from-top entry minus the top entry, taken modulo 2^16.
- R7: Add and subtract ignore `instr_addr`. They cause no memory access and complete in one cycle, so `instr_ready` stays high.
- R8: The stack holds 8 entries of 16 bits and returns them in last-in, first-out order.
- R9: A load issued while the stack holds 8 entries sets `ovf_flag`. It leaves the stack unchanged and makes no memory access.
- R10: An add or subtract issued with fewer than two entries on the stack, or a store issued on an empty stack, sets `unf_flag`. It leaves the stack unchanged and makes no memory access.
- R11: Once set, `ovf_flag` and `unf_flag` stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | The block can accept an instruction |
| instr_op | input | 2 | Opcode: 0 load, 1 store, 2 add, 3 subtract |
| instr_addr | input | 12 | Memory address for load and store |
| mem_rd | output | 1 | Read strobe for the data memory |
| mem_wr | output | 1 | Write strobe for the data memory |
| mem_addr | output | 12 | Address for the data memory access |
| mem_wdata | output | 16 | Data written on a store |
| mem_rdata | input | 16 | Data returned by the memory in the read cycle |
| ovf_flag | output | 1 | Sticky stack overflow indication |
| unf_flag | output | 1 | Sticky stack underflow indication |

## Verification
The bound assertions check several properties on every cycle:
- the strobes are mutually exclusive;
- a memory access lasts a single cycle and always coincides with a stall;
- an arithmetic instruction never leads to an access;
- an accepted store either writes or raises underflow;
- both flags are sticky.

The data path can only be judged by the bench's scenarios. These cover the operand order of subtraction, wraparound sums, the last-in, first-out order across the full depth, and the stack contents left intact after an overflowing load or an underflowing add or store. The bench's scoreboard predicts each memory write from its own stack model and compares it with what the block stores.

// File: rtl/zs_pkg.sv
package zs_pkg;

    parameter int ZS_DATA_W = 16;
    parameter int ZS_ADDR_W = 12;
    parameter int ZS_DEPTH  = 8;

    // instruction opcodes (encoding is part of the interface)
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_ADD   = 2'd2,
        OP_SUB   = 2'd3
    } zs_op_e;

    // commands from the controller to the operand stack
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_FOLD = 2'd3   // drop two entries, push one
    } zs_stk_cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } zs_state_e;

endpackage

// File: rtl/zs_stack.sv
module zs_stack
    import zs_pkg::*;
#(
    parameter int DATA_W = ZS_DATA_W,
    parameter int DEPTH  = ZS_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  zs_stk_cmd_e                  cmd,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            top,
    output logic [DATA_W-1:0]            second,
    output logic                         full,
    output logic                         empty,
    output logic                         has_two
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    logic [PTR_W-1:0] push_idx;
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] sec_idx;

    always_comb begin
        push_idx = PTR_W'(stk_q.cnt);
        top_idx  = PTR_W'(stk_q.cnt - CNT_W'(1));
        sec_idx  = PTR_W'(stk_q.cnt - CNT_W'(2));
        full     = (stk_q.cnt == CNT_W'(DEPTH));
        empty    = (stk_q.cnt == '0);
        has_two  = (stk_q.cnt >= CNT_W'(2));
        top      = stk_q.ent[top_idx];
        second   = stk_q.ent[sec_idx];
    end

    always_comb begin
        stk_d = stk_q;
        case (cmd)
            STK_PUSH: begin
                if (!full) begin
                    stk_d.ent[push_idx] = wdata;
                    stk_d.cnt           = stk_q.cnt + CNT_W'(1);
                end
            end
            STK_POP: begin
                if (!empty) begin
                    stk_d.cnt = stk_q.cnt - CNT_W'(1);
                end
            end
            STK_FOLD: begin
                if (has_two) begin
                    stk_d.ent[sec_idx] = wdata;
                    stk_d.cnt          = stk_q.cnt - CNT_W'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

endmodule

// File: rtl/zs_alu.sv
module zs_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] lhs,   // second-from-top entry
    input  logic [DATA_W-1:0] rhs,   // top entry
    input  logic              sub,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        if (sub) begin
            res = lhs - rhs;
        end else begin
            res = lhs + rhs;
        end
    end

endmodule

// File: rtl/zs_ctrl.sv
module zs_ctrl
    import zs_pkg::*;
#(
    parameter int DATA_W = ZS_DATA_W,
    parameter int ADDR_W = ZS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [1:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    output logic              instr_ready,
    input  logic              stk_full,
    input  logic              stk_empty,
    input  logic              stk_has_two,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [DATA_W-1:0] mem_rdata,
    output zs_stk_cmd_e       stk_cmd,
    output logic [DATA_W-1:0] stk_wdata,
    output logic              alu_sub,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ovf_flag,
    output logic              unf_flag
);

    typedef struct packed {
        zs_state_e         state;
        zs_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic              ovf;
        logic              unf;
    } ctrl_t;

    ctrl_t  ctl_d, ctl_q;
    zs_op_e in_op;

    assign in_op = zs_op_e'(instr_op);

    always_comb begin
        ctl_d     = ctl_q;
        stk_cmd   = STK_HOLD;
        stk_wdata = alu_res;
        alu_sub   = (in_op == OP_SUB);
        case (ctl_q.state)
            ST_IDLE: begin
                if (instr_valid) begin
                    case (in_op)
                        OP_LOAD: begin
                            if (stk_full) begin
                                ctl_d.ovf = 1'b1;
                            end else begin
                                ctl_d.state = ST_MEM;
                                ctl_d.op    = in_op;
                                ctl_d.addr  = instr_addr;
                            end
                        end
                        OP_STORE: begin
                            if (stk_empty) begin
                                ctl_d.unf = 1'b1;
                            end else begin
                                ctl_d.state = ST_MEM;
                                ctl_d.op    = in_op;
                                ctl_d.addr  = instr_addr;
                            end
                        end
                        default: begin
                            if (!stk_has_two) begin
                                ctl_d.unf = 1'b1;
                            end else begin
                                stk_cmd = STK_FOLD;
                            end
                        end
                    endcase
                end
            end
            ST_MEM: begin
                ctl_d.state = ST_IDLE;
                if (ctl_q.op == OP_LOAD) begin
                    stk_cmd   = STK_PUSH;
                    stk_wdata = mem_rdata;
                end else begin
                    stk_cmd = STK_POP;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, op: OP_LOAD, addr: '0, ovf: 1'b0, unf: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign instr_ready = (ctl_q.state == ST_IDLE);
    assign mem_rd      = (ctl_q.state == ST_MEM) && (ctl_q.op == OP_LOAD);
    assign mem_wr      = (ctl_q.state == ST_MEM) && (ctl_q.op == OP_STORE);
    assign mem_addr    = ctl_q.addr;
    assign ovf_flag    = ctl_q.ovf;
    assign unf_flag    = ctl_q.unf;

endmodule

// File: rtl/zs_eval.sv
module zs_eval
    import zs_pkg::*;
#(
    parameter int DATA_W = ZS_DATA_W,
    parameter int ADDR_W = ZS_ADDR_W,
    parameter int DEPTH  = ZS_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [1:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ovf_flag,
    output logic              unf_flag
);

    zs_stk_cmd_e       stk_cmd;
    logic [DATA_W-1:0] stk_wdata;
    logic [DATA_W-1:0] stk_top;
    logic [DATA_W-1:0] stk_second;
    logic              stk_full;
    logic              stk_empty;
    logic              stk_has_two;
    logic [DATA_W-1:0] alu_res;
    logic              alu_sub;

    zs_stack #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (stk_cmd),
        .wdata   (stk_wdata),
        .top     (stk_top),
        .second  (stk_second),
        .full    (stk_full),
        .empty   (stk_empty),
        .has_two (stk_has_two)
    );

    zs_alu #(
        .DATA_W (DATA_W)
    ) i_alu (
        .lhs (stk_second),
        .rhs (stk_top),
        .sub (alu_sub),
        .res (alu_res)
    );

    zs_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .instr_addr  (instr_addr),
        .instr_ready (instr_ready),
        .stk_full    (stk_full),
        .stk_empty   (stk_empty),
        .stk_has_two (stk_has_two),
        .alu_res     (alu_res),
        .mem_rdata   (mem_rdata),
        .stk_cmd     (stk_cmd),
        .stk_wdata   (stk_wdata),
        .alu_sub     (alu_sub),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_addr    (mem_addr),
        .ovf_flag    (ovf_flag),
        .unf_flag    (unf_flag)
    );

    assign mem_wdata = stk_top;

endmodule

// File: rtl/zs_eval_chk.sv
module zs_eval_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic       instr_ready,
    input logic [1:0] instr_op,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ovf_flag,
    input logic       unf_flag
);

    // R2: a memory access cycle is always a stall cycle
    a_r2_stall_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !instr_ready);

    // R2: an access lasts exactly one cycle
    a_r2_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

    // R2: never both strobes
    a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: arithmetic never touches memory
    a_r7_arith_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && instr_op[1]) |=> !(mem_rd || mem_wr));

    // R4 / R10: an accepted store either writes or flags underflow
    a_r4_store_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && instr_op == 2'd1) |=> (mem_wr || unf_flag));

    // R3 / R9: an accepted load either reads or flags overflow
    a_r3_load_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && instr_op == 2'd0) |=> (mem_rd || ovf_flag));

    // R11: sticky flags
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

endmodule

bind zs_eval zs_eval_chk i_zs_eval_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_op    (instr_op),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .ovf_flag    (ovf_flag),
    .unf_flag    (unf_flag)
);

// File: tb/test_zs_eval.sv
module test_zs_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [1:0]  instr_op = 2'd0;
    logic [11:0] instr_addr = '0;
    logic        mem_rd;
    logic        mem_wr;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        ovf_flag;
    logic        unf_flag;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    zs_eval i_zs_eval (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_ready (instr_ready),
        .instr_op    (instr_op),
        .instr_addr  (instr_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .ovf_flag    (ovf_flag),
        .unf_flag    (unf_flag)
    );

    // memory model: asynchronous read, write at the clock edge
    logic [15:0] dmem [64];
    logic [15:0] ref_mem [64];
    assign mem_rdata = dmem[mem_addr[5:0]];
    always @(posedge clk) begin
        if (mem_wr) dmem[mem_addr[5:0]] <= mem_wdata;
    end

    // reference model
    logic [15:0] mdl[$];
    logic [27:0] sb[$];
    logic        exp_ovf = 1'b0;
    logic        exp_unf = 1'b0;

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // scoreboard monitor for memory writes
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            if (sb.size() == 0) begin
                check(1'b0, "R4", "unexpected write addr", int'(mem_addr), 0);
            end else begin
                logic [27:0] e;
                e = sb.pop_front();
                check(mem_addr == e[27:16], "R4", "write address",
                      int'(mem_addr), int'(e[27:16]));
                check(mem_wdata == e[15:0], "R4", "write data",
                      int'(mem_wdata), int'(e[15:0]));
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        mdl.delete();
        exp_ovf = 1'b0;
        exp_unf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(instr_ready == 1'b1, "R1", "ready after reset", int'(instr_ready), 1);
        check(!ovf_flag && !unf_flag, "R1", "flags after reset",
              int'({ovf_flag, unf_flag}), 0);
        check(!mem_rd && !mem_wr, "R1", "strobes after reset",
              int'({mem_rd, mem_wr}), 0);
    endtask

    // driver: issue one instruction and predict its effect
    task automatic issue(input logic [1:0] op, input logic [11:0] addr, input string req);
        logic access;
        access = 1'b0;
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = op;
        instr_addr  = addr;
        case (op)
            2'd0: begin
                if (mdl.size() == 8) exp_ovf = 1'b1;
                else begin mdl.push_back(ref_mem[addr[5:0]]); access = 1'b1; end
            end
            2'd1: begin
                if (mdl.size() == 0) exp_unf = 1'b1;
                else begin
                    logic [15:0] v;
                    v = mdl.pop_back();
                    sb.push_back({addr, v});
                    ref_mem[addr[5:0]] = v;
                    access = 1'b1;
                end
            end
            default: begin
                if (mdl.size() < 2) exp_unf = 1'b1;
                else begin
                    logic [15:0] t;
                    logic [15:0] s;
                    t = mdl.pop_back();
                    s = mdl.pop_back();
                    mdl.push_back(op == 2'd3 ? s - t : s + t);
                end
            end
        endcase
        @(negedge clk);
        instr_valid = 1'b0;
        if (access) begin
            check(!instr_ready, "R2", "stall during access", int'(instr_ready), 0);
            check(mem_rd == (op == 2'd0) && mem_wr == (op == 2'd1), {req, "/R3"},
                  "strobe kind", int'({mem_rd, mem_wr}), int'({op == 2'd0, op == 2'd1}));
            check(mem_addr == addr, {req, "/R3"}, "access address",
                  int'(mem_addr), int'(addr));
            @(negedge clk);
            check(instr_ready && !mem_rd && !mem_wr, "R2", "ready after access",
                  int'({instr_ready, mem_rd, mem_wr}), 4);
        end else begin
            check(instr_ready && !mem_rd && !mem_wr, req, "no access, no stall",
                  int'({instr_ready, mem_rd, mem_wr}), 4);
        end
        check(ovf_flag == exp_ovf, req, "ovf_flag", int'(ovf_flag), int'(exp_ovf));
        check(unf_flag == exp_unf, req, "unf_flag", int'(unf_flag), int'(exp_unf));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            dmem[i]    = 16'h1000 + 16'(i * 37);
            ref_mem[i] = 16'h1000 + 16'(i * 37);
        end
        dmem[1] = 16'd5;      ref_mem[1] = 16'd5;
        dmem[2] = 16'd7;      ref_mem[2] = 16'd7;
        dmem[6] = 16'hFFFF;   ref_mem[6] = 16'hFFFF;

        do_reset();   // R1

        // R5: X = Y + Z
        issue(2'd0, 12'd1, "R3");
        issue(2'd0, 12'd2, "R3");
        issue(2'd2, 12'd0, "R5");
        issue(2'd1, 12'd3, "R4");   // expect 12

        // R6: operand order of subtraction
        issue(2'd0, 12'd2, "R3");
        issue(2'd0, 12'd1, "R3");
        issue(2'd3, 12'd0, "R6");
        issue(2'd1, 12'd4, "R6");   // 7-5 = 2
        issue(2'd0, 12'd1, "R3");
        issue(2'd0, 12'd2, "R3");
        issue(2'd3, 12'hABC, "R7"); // address ignored
        issue(2'd1, 12'd5, "R6");   // 5-7 = FFFE

        // R5 wraparound, R7 address ignored
        issue(2'd0, 12'd6, "R3");
        issue(2'd0, 12'd1, "R3");
        issue(2'd2, 12'hFFF, "R7");
        issue(2'd1, 12'd7, "R5");   // FFFF+5 = 4

        // R8: LIFO over full depth
        for (int i = 0; i < 8; i++) issue(2'd0, 12'(40 + i), "R8");
        for (int i = 0; i < 8; i++) issue(2'd1, 12'(20 + i), "R8");

        // R9: overflow leaves stack intact
        for (int i = 0; i < 8; i++) issue(2'd0, 12'(48 + i), "R9");
        issue(2'd0, 12'd60, "R9");
        for (int i = 0; i < 8; i++) issue(2'd1, 12'(28 + i), "R9");
        issue(2'd0, 12'd1, "R11");  // flag stays set
        issue(2'd1, 12'd36, "R11");

        // R10: arithmetic with one entry
        do_reset();
        issue(2'd0, 12'd2, "R3");
        issue(2'd2, 12'd0, "R10");
        issue(2'd1, 12'd37, "R10"); // value unchanged (7)
        // R10: store on empty stack
        do_reset();
        issue(2'd1, 12'd38, "R10");
        issue(2'd3, 12'd0, "R10");
        issue(2'd0, 12'd1, "R11");
        issue(2'd1, 12'd39, "R11");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R4", "all expected writes seen", sb.size(), 0);
        check(dmem[3] == 16'd12 && dmem[5] == 16'hFFFE && dmem[7] == 16'd4, "R5",
              "stored results", int'(dmem[5]), 16'hFFFE);
        finish_run();
    end

endmodule